// File: doc/BRIEF.md
# Templated Ternary Rule Matcher

This block classifies packets against a table of ternary rules. The rules are grouped into blocks of equal size. A parser outside the block supplies a key: source and destination MAC, ethertype, inner tag, source and destination IP (IPv4 in the low 32 bits, IPv6 as the full 128 bits), ToS/protocol, L4 ports, ICMP/IGMP word, a 64-bit source port mask and a 20-bit vector of fixed header attributes. When the key-valid strobe is high, every enabled rule on the matching side of the ingress/egress split compares its twelve 16-bit value/mask slots and its fixed ternary fields against the key. One cycle later the block reports whether a rule hit, the index of the winning rule and that rule's 32-bit action word.

A slot does not have a fixed meaning. Each block holds a 6-bit selector with two 3-bit template numbers. Each rule picks one of the two with bit 0 of its template ID. The chosen template fixes which 16-bit key word is compared in each of the twelve slots. Rules, selectors, the block enables and the cutline are written through simple write-enable ports.

Top module: `tmpl_rule_match`

## Requirements
- R1: A slot matches when ((key word XOR value) AND mask) is zero. A rule hits only if all twelve slots match. Slot s of a rule is written as word s (0..11), with the value in bits [15:0] and the mask in bits [31:16].
- R2: The templates give the key word for slots 0..11 as follows. Template 0: SPM0, SPM1, ITAG, SMAC0, SMAC1, SMAC2, DMAC0, DMAC1, DMAC2, ETH, SPM2, SPM3. Template 1: SIP0, SIP1, DIP0, DIP1, TOSP, SPORT, DPORT, ICMP, SPM0..SPM3. Template 2: DMAC0..DMAC2, ITAG, ETH, TOSP, DPORT, SPORT, SIP0, SIP1, DIP0, DIP1. Template 3: DIP0..DIP7, DPORT, SPORT, ICMP, TOSP. Template 4: SIP0..SIP7, SPM0..SPM3.
- R3: A rule whose template-ID bit 0 is 0 uses selector bits [2:0] of its block. If that bit is 1, the rule uses bits [5:3]. Template numbers 5 to 7 supply all-zero key words.
- R4: Word 12 bits [19:0] hold the fixed-field value and word 13 bits [19:0] hold its mask. Both are compared ternary against the fixed-field key input. Bits [21:20] of words 12 and 13 hold the template-ID value and mask, and they are compared against the selector slot in use (0 or 1).
- R5: Bit 31 of word 12 is the valid bit. A rule with this bit clear never hits.
- R6: A rule in a block whose enable bit is 0 never hits.
- R7: Blocks whose index is below the 5-bit cutline serve ingress keys. Blocks at or above the cutline serve egress keys. The cutline resets to CUT_RST.
- R8: When several rules hit, the one with the lowest global index (block*NRULE + rule) wins, and its word 14 becomes the action.
- R9: The result appears in the cycle after key_valid. The result valid flag equals the strobe of the previous cycle. If there is no hit or no lookup, the hit flag, the index and the action are all zero.
- R10: Word k of a MAC, IP or port-mask key field is bits [16k+15:16k], so word 0 of a MAC holds address bytes 4 and 5 and word 0 of an IPv4 address is its low half.
- R11: A rule write to word 15 has no effect.
- R12: After reset all rules are invalid, all blocks are disabled, all selectors are 0 and all result outputs are 0.
- R13: A lookup in the same cycle as a write uses the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rule_we | input | 1 | Rule word write enable |
| rule_addr | input | IW | Global rule index |
| rule_word | input | 4 | Word within the rule (0..15) |
| rule_wdata | input | 32 | Rule word data |
| sel_we | input | 1 | Selector write enable |
| sel_blk | input | BW | Block whose selector is written |
| sel_wdata | input | 6 | Two 3-bit template numbers |
| glb_we | input | 1 | Enable/cutline write enable |
| glb_en | input | NBLK | Per-block lookup enables |
| glb_cut | input | 5 | First egress block |
| key_valid | input | 1 | Lookup strobe |
| key_egress | input | 1 | 1 = egress lookup, 0 = ingress |
| key_smac | input | 48 | Source MAC |
| key_dmac | input | 48 | Destination MAC |
| key_etype | input | 16 | Ethertype |
| key_itag | input | 16 | Inner tag |
| key_sip | input | 128 | Source IP |
| key_dip | input | 128 | Destination IP |
| key_tosp | input | 16 | ToS and protocol |
| key_sport | input | 16 | L4 source port |
| key_dport | input | 16 | L4 destination port |
| key_icmp | input | 16 | ICMP/IGMP word |
| key_spm | input | 64 | Source port mask |
| key_fix | input | 20 | Fixed header attributes |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | A rule hit |
| res_idx | output | IW | Winning rule index |
| res_act | output | 32 | Winning action word |

## Verification
The hardest case to reach from the ports is several rules hitting at once, in different blocks and through different templates, so that the priority order really decides the result. Random keys and rule values are therefore drawn from a tiny alphabet of two bits per 16-bit word, and most rule masks are zero. This keeps simultaneous hits common while selectors, enables and the cutline change underneath. Directed steps add the cases that random stimulus rarely produces: an out-of-range template number, a template-ID value that can never match, and a write that collides with a lookup.

// File: rtl/tmpl_rule_match.sv
module tmpl_rule_match #(
  parameter int NBLK    = 4,
  parameter int NRULE   = 8,
  parameter int CUT_RST = 2,
  localparam int NR = NBLK * NRULE,
  localparam int IW = (NR > 1) ? $clog2(NR) : 1,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rule_we,
  input  logic [IW-1:0]   rule_addr,
  input  logic [3:0]      rule_word,
  input  logic [31:0]     rule_wdata,
  input  logic            sel_we,
  input  logic [BW-1:0]   sel_blk,
  input  logic [5:0]      sel_wdata,
  input  logic            glb_we,
  input  logic [NBLK-1:0] glb_en,
  input  logic [4:0]      glb_cut,
  input  logic            key_valid,
  input  logic            key_egress,
  input  logic [47:0]     key_smac,
  input  logic [47:0]     key_dmac,
  input  logic [15:0]     key_etype,
  input  logic [15:0]     key_itag,
  input  logic [127:0]    key_sip,
  input  logic [127:0]    key_dip,
  input  logic [15:0]     key_tosp,
  input  logic [15:0]     key_sport,
  input  logic [15:0]     key_dport,
  input  logic [15:0]     key_icmp,
  input  logic [63:0]     key_spm,
  input  logic [19:0]     key_fix,
  output logic            res_valid,
  output logic            res_hit,
  output logic [IW-1:0]   res_idx,
  output logic [31:0]     res_act
);
  localparam int NSLOT = 12;
  localparam int NKW   = 64;

  localparam logic [6*NSLOT-1:0] TPL0 = {6'd4, 6'd3, 6'd11, 6'd7, 6'd6, 6'd5, 6'd10, 6'd9, 6'd8, 6'd12, 6'd2, 6'd1};
  localparam logic [6*NSLOT-1:0] TPL1 = {6'd4, 6'd3, 6'd2, 6'd1, 6'd32, 6'd31, 6'd30, 6'd29, 6'd22, 6'd21, 6'd14, 6'd13};
  localparam logic [6*NSLOT-1:0] TPL2 = {6'd22, 6'd21, 6'd14, 6'd13, 6'd30, 6'd31, 6'd29, 6'd11, 6'd12, 6'd7, 6'd6, 6'd5};
  localparam logic [6*NSLOT-1:0] TPL3 = {6'd29, 6'd32, 6'd30, 6'd31, 6'd28, 6'd27, 6'd26, 6'd25, 6'd24, 6'd23, 6'd22, 6'd21};
  localparam logic [6*NSLOT-1:0] TPL4 = {6'd4, 6'd3, 6'd2, 6'd1, 6'd20, 6'd19, 6'd18, 6'd17, 6'd16, 6'd15, 6'd14, 6'd13};

  function automatic logic [5:0] tfield(input logic [2:0] t, input int s);
    case (t)
      3'd0:    tfield = TPL0[s*6 +: 6];
      3'd1:    tfield = TPL1[s*6 +: 6];
      3'd2:    tfield = TPL2[s*6 +: 6];
      3'd3:    tfield = TPL3[s*6 +: 6];
      3'd4:    tfield = TPL4[s*6 +: 6];
      default: tfield = 6'd0;
    endcase
  endfunction

  logic [31:0]     slot_q [NR][NSLOT];
  logic [21:0]     fv_q [NR];
  logic [21:0]     fm_q [NR];
  logic [31:0]     act_q [NR];
  logic [NR-1:0]   vld_q;
  logic [5:0]      sel_q [NBLK];
  logic [NBLK-1:0] en_q;
  logic [4:0]      cut_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NR; g++) begin
        for (int s = 0; s < NSLOT; s++) slot_q[g][s] <= '0;
        fv_q[g]  <= '0;
        fm_q[g]  <= '0;
        act_q[g] <= '0;
      end
      vld_q <= '0;
      for (int b = 0; b < NBLK; b++) sel_q[b] <= '0;
      en_q  <= '0;
      cut_q <= 5'(CUT_RST);
    end else begin
      if (rule_we) begin
        if (rule_word < 4'd12) slot_q[rule_addr][rule_word] <= rule_wdata;
        else if (rule_word == 4'd12) begin
          fv_q[rule_addr]  <= rule_wdata[21:0];
          vld_q[rule_addr] <= rule_wdata[31];
        end
        else if (rule_word == 4'd13) fm_q[rule_addr] <= rule_wdata[21:0];
        else if (rule_word == 4'd14) act_q[rule_addr] <= rule_wdata;
      end
      if (sel_we) sel_q[sel_blk] <= sel_wdata;
      if (glb_we) begin
        en_q  <= glb_en;
        cut_q <= glb_cut;
      end
    end
  end

  logic [15:0] kw [NKW];
  always_comb begin
    for (int i = 0; i < NKW; i++) kw[i] = '0;
    for (int k = 0; k < 4; k++) kw[1+k] = key_spm[16*k +: 16];
    for (int k = 0; k < 3; k++) begin
      kw[5+k] = key_dmac[16*k +: 16];
      kw[8+k] = key_smac[16*k +: 16];
    end
    kw[11] = key_etype;
    kw[12] = key_itag;
    for (int k = 0; k < 8; k++) begin
      kw[13+k] = key_sip[16*k +: 16];
      kw[21+k] = key_dip[16*k +: 16];
    end
    kw[29] = key_tosp;
    kw[30] = key_sport;
    kw[31] = key_dport;
    kw[32] = key_icmp;
  end

  logic [15:0] bk [NBLK][2][NSLOT];
  always_comb begin
    for (int b = 0; b < NBLK; b++)
      for (int j = 0; j < 2; j++)
        for (int s = 0; s < NSLOT; s++)
          bk[b][j][s] = kw[tfield(sel_q[b][j*3 +: 3], s)];
  end

  logic [NR-1:0] hit_v;
  for (genvar g = 0; g < NR; g++) begin : g_rule
    localparam int B = g / NRULE;
    logic side, fok, sok;
    assign side = key_egress ? (cut_q <= 5'(B)) : (cut_q > 5'(B));
    assign fok  = (((fv_q[g] ^ {1'b0, fv_q[g][20], key_fix}) & fm_q[g]) == '0);
    always_comb begin
      sok = 1'b1;
      for (int s = 0; s < NSLOT; s++)
        if (((bk[B][fv_q[g][20]][s] ^ slot_q[g][s][15:0]) & slot_q[g][s][31:16]) != '0) sok = 1'b0;
    end
    assign hit_v[g] = vld_q[g] & en_q[B] & side & fok & sok;
  end

  logic [IW-1:0] win;
  always_comb begin
    win = '0;
    for (int g = NR - 1; g >= 0; g--)
      if (hit_v[g]) win = IW'(g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_act   <= '0;
    end else begin
      res_valid <= key_valid;
      res_hit   <= key_valid && (hit_v != '0);
      res_idx   <= (key_valid && (hit_v != '0)) ? win : '0;
      res_act   <= (key_valid && (hit_v != '0)) ? act_q[win] : '0;
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> res_valid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> (!res_valid && !res_hit && res_idx == '0 && res_act == '0));
  a_r5_no_valid_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && vld_q == '0) |=> !res_hit);
  a_r6_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && en_q == '0) |=> !res_hit);
  a_r7_no_egress_side: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_egress && cut_q >= 5'(NBLK)) |=> !res_hit);
  a_r7_no_ingress_side: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !key_egress && cut_q == '0) |=> !res_hit);
endmodule

// File: tb/sim_tmpl_rule_match.sv
module sim_tmpl_rule_match;
  localparam int NBLK = 4;
  localparam int NRULE = 8;
  localparam int CUT_RST = 2;
  localparam int NR = NBLK * NRULE;
  localparam int IW = $clog2(NR);
  localparam int BW = $clog2(NBLK);

  logic clk = 1'b0, rst_n = 1'b0;
  logic rule_we = 0, sel_we = 0, glb_we = 0, key_valid = 0, key_egress = 0;
  logic [IW-1:0] rule_addr = '0;
  logic [3:0] rule_word = '0;
  logic [31:0] rule_wdata = '0;
  logic [BW-1:0] sel_blk = '0;
  logic [5:0] sel_wdata = '0;
  logic [NBLK-1:0] glb_en = '0;
  logic [4:0] glb_cut = '0;
  logic [47:0] key_smac = '0, key_dmac = '0;
  logic [15:0] key_etype = '0, key_itag = '0, key_tosp = '0, key_sport = '0, key_dport = '0, key_icmp = '0;
  logic [127:0] key_sip = '0, key_dip = '0;
  logic [63:0] key_spm = '0;
  logic [19:0] key_fix = '0;
  logic res_valid, res_hit;
  logic [IW-1:0] res_idx;
  logic [31:0] res_act;

  tmpl_rule_match #(.NBLK(NBLK), .NRULE(NRULE), .CUT_RST(CUT_RST)) u0 (.*);

  always #10 clk = ~clk;

  logic [31:0] m_word [NR][15];
  logic [5:0] m_sel [NBLK];
  logic [NBLK-1:0] m_en;
  logic [4:0] m_cut;
  int nchk = 0, nfail = 0;

  function automatic logic [15:0] w16(input logic [127:0] v, input int k);
    return v[16*k +: 16];
  endfunction

  function automatic logic [15:0] key_word(input int t, input int s);
    logic [15:0] r = '0;
    case (t)
      0: case (s)
           0: r = w16(key_spm, 0);  1: r = w16(key_spm, 1);  2: r = key_itag;
           3: r = w16(key_smac, 0); 4: r = w16(key_smac, 1); 5: r = w16(key_smac, 2);
           6: r = w16(key_dmac, 0); 7: r = w16(key_dmac, 1); 8: r = w16(key_dmac, 2);
           9: r = key_etype; 10: r = w16(key_spm, 2); default: r = w16(key_spm, 3);
         endcase
      1: case (s)
           0: r = w16(key_sip, 0); 1: r = w16(key_sip, 1); 2: r = w16(key_dip, 0);
           3: r = w16(key_dip, 1); 4: r = key_tosp; 5: r = key_sport; 6: r = key_dport;
           7: r = key_icmp; default: r = w16(key_spm, s - 8);
         endcase
      2: case (s)
           0, 1, 2: r = w16(key_dmac, s); 3: r = key_itag; 4: r = key_etype;
           5: r = key_tosp; 6: r = key_dport; 7: r = key_sport;
           8, 9: r = w16(key_sip, s - 8); default: r = w16(key_dip, s - 10);
         endcase
      3: if (s < 8) r = w16(key_dip, s);
         else case (s) 8: r = key_dport; 9: r = key_sport; 10: r = key_icmp; default: r = key_tosp; endcase
      4: r = (s < 8) ? w16(key_sip, s) : w16(key_spm, s - 8);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic model(output logic hit, output int idx, output logic [31:0] act);
    int b, j, t;
    logic ok;
    hit = 0; idx = 0; act = '0;
    for (int g = NR - 1; g >= 0; g--) begin
      b = g / NRULE;
      j = int'(m_word[g][12][20]);
      t = j ? int'(m_sel[b][5:3]) : int'(m_sel[b][2:0]);
      ok = m_word[g][12][31] && m_en[b] && ((b >= int'(m_cut)) == key_egress);
      if (((m_word[g][12][21:20] ^ 2'(j)) & m_word[g][13][21:20]) != 0) ok = 0;
      if (((m_word[g][12][19:0] ^ key_fix) & m_word[g][13][19:0]) != 0) ok = 0;
      for (int s = 0; s < 12; s++)
        if (((key_word(t, s) ^ m_word[g][s][15:0]) & m_word[g][s][31:16]) != 0) ok = 0;
      if (ok) begin hit = 1; idx = g; act = m_word[g][14]; end
    end
  endtask

  task automatic tick(input string tag);
    logic ev, eh;
    logic [IW-1:0] ei;
    logic [31:0] ea;
    int ii;
    ev = key_valid; eh = 0; ei = '0; ea = '0;
    if (key_valid) begin model(eh, ii, ea); ei = IW'(ii); end
    if (rule_we && rule_word < 4'd15) m_word[rule_addr][rule_word] = rule_wdata;
    if (sel_we) m_sel[sel_blk] = sel_wdata;
    if (glb_we) begin m_en = glb_en; m_cut = glb_cut; end
    @(posedge clk);
    @(negedge clk);
    nchk++;
    if ({res_valid, res_hit, res_idx, res_act} !== {ev, eh, ei, ea}) begin
      nfail++;
      $display("FAIL %s: valid/hit/idx/act actual %b/%b/%0d/%h expected %b/%b/%0d/%h",
               tag, res_valid, res_hit, res_idx, res_act, ev, eh, ei, ea);
    end
  endtask

  task automatic wr(input int a, input int w, input logic [31:0] d, input string tag);
    rule_we = 1; rule_addr = IW'(a); rule_word = 4'(w); rule_wdata = d;
    tick(tag);
    rule_we = 0;
  endtask

  task automatic wsel(input int b, input logic [5:0] v, input string tag);
    sel_we = 1; sel_blk = BW'(b); sel_wdata = v;
    tick(tag);
    sel_we = 0;
  endtask

  task automatic wglb(input logic [NBLK-1:0] en, input logic [4:0] cut, input string tag);
    glb_we = 1; glb_en = en; glb_cut = cut;
    tick(tag);
    glb_we = 0;
  endtask

  task automatic look(input logic eg, input string tag);
    key_valid = 1; key_egress = eg;
    tick(tag);
    key_valid = 0;
  endtask

  task automatic clear_key();
    key_smac = '0; key_dmac = '0; key_etype = '0; key_itag = '0; key_tosp = '0;
    key_sport = '0; key_dport = '0; key_icmp = '0; key_sip = '0; key_dip = '0;
    key_spm = '0; key_fix = '0;
  endtask

  function automatic logic [15:0] small16();
    return 16'($urandom % 4);
  endfunction

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog R9: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int g = 0; g < NR; g++) for (int w = 0; w < 15; w++) m_word[g][w] = '0;
    for (int b = 0; b < NBLK; b++) m_sel[b] = '0;
    m_en = '0; m_cut = 5'(CUT_RST);
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick("R12 reset outputs");
    look(0, "R12 no valid rules after reset");
    wglb(4'hF, 5'd2, "R7 enable all, cutline 2");
    wsel(0, 6'b001_000, "R3 block0 selectors 0/1");
    wsel(1, 6'b010_011, "R3 block1 selectors 3/2");
    wsel(2, 6'b001_100, "R3 block2 selectors 4/1");
    wsel(3, 6'b000_111, "R3 block3 selectors 7/0");
    wr(2, 3, 32'hFFFF_4455, "R1 rule2 smac word0");
    wr(2, 5, 32'hFFFF_0011, "R1 rule2 smac word2");
    wr(2, 13, 32'h0030_0000, "R4 rule2 tid mask");
    wr(2, 14, 32'hA000_0002, "R8 rule2 action");
    wr(2, 12, 32'h8000_0000, "R5 rule2 valid");
    key_smac = 48'h0011_2233_4455;
    look(0, "R10 smac words hit rule2");
    key_smac = 48'h0011_2233_4456;
    look(0, "R1 one bit off misses");
    wr(4, 0, 32'hFFFF_0001, "R1 rule4 sip0");
    wr(4, 1, 32'hFFFF_C0A8, "R1 rule4 sip1");
    wr(4, 13, 32'h0030_0000, "R4 rule4 tid mask");
    wr(4, 14, 32'hA000_0004, "R8 rule4 action");
    wr(4, 12, 32'h8010_0000, "R3 rule4 uses selector slot 1");
    key_sip = 128'hC0A8_0001;
    look(0, "R3 template1 ipv4 hit rule4");
    key_smac = 48'h0011_2233_4455;
    look(0, "R8 rules 2 and 4 both hit, lowest wins");
    wr(4, 12, 32'h8011_4000, "R4 rule4 spn value 5");
    wr(4, 13, 32'h003F_C000, "R4 rule4 spn mask");
    key_smac = '0; key_fix = 20'h14000;
    look(0, "R4 fixed field match");
    key_fix = 20'h18000;
    look(0, "R4 fixed field mismatch");
    wr(6, 13, 32'h0030_0000, "R4 rule6 tid mask");
    wr(6, 12, 32'h8020_0000, "R4 rule6 tid value 2");
    look(0, "R4 tid value 2 never hits");
    key_smac = 48'h0011_2233_4455;
    wglb(4'hE, 5'd2, "R6 disable block0");
    look(0, "R6 disabled block gives no hit");
    wglb(4'hF, 5'd2, "R6 re-enable block0");
    wr(7, 15, 32'hFFFF_FFFF, "R11 write word 15");
    look(0, "R11 word 15 write has no effect");
    clear_key();
    wr(16, 7, 32'hFFFF_2001, "R2 rule16 template4 sip7");
    wr(16, 13, 32'h0030_0000, "R4 rule16 tid mask");
    wr(16, 12, 32'h8000_0000, "R5 rule16 valid");
    key_sip = 128'h2001 << 112;
    look(1, "R7 egress lookup hits block2");
    look(0, "R7 ingress lookup skips block2");
    wglb(4'hF, 5'd3, "R7 cutline 3");
    look(1, "R7 block2 now ingress");
    look(0, "R7 ingress now hits rule16");
    wglb(4'hF, 5'd2, "R7 cutline back to 2");
    clear_key();
    wr(24, 0, 32'hFFFF_0000, "R3 rule24 slot0 zero");
    wr(24, 13, 32'h0030_0000, "R4 rule24 tid mask");
    wr(24, 12, 32'h8000_0000, "R5 rule24 valid");
    look(1, "R3 template 7 yields zero words");
    wr(24, 0, 32'hFFFF_0001, "R3 rule24 slot0 one");
    look(1, "R3 template 7 nonzero value misses");
    key_valid = 1; key_egress = 1;
    wr(25, 12, 32'h8000_0000, "R13 write during lookup sees old table");
    key_valid = 0;
    look(1, "R13 next lookup sees new rule");
    wr(25, 12, 32'h0000_0000, "R5 rule25 invalid");
    look(1, "R5 invalid rule no hit");
    for (int n = 0; n < 4000; n++) begin
      rule_we = ($urandom % 4) == 0;
      rule_addr = IW'($urandom);
      rule_word = 4'($urandom);
      if (rule_word < 4'd12)
        rule_wdata = {(($urandom % 8) == 0) ? 16'($urandom & $urandom) : 16'h0, small16()};
      else if (rule_word == 4'd12)
        rule_wdata = {($urandom % 4) != 0, 9'h0, 2'($urandom), 20'($urandom & $urandom & $urandom)};
      else if (rule_word == 4'd13)
        rule_wdata = {10'h0, 2'($urandom), 20'($urandom & $urandom & $urandom & $urandom)};
      else rule_wdata = $urandom;
      sel_we = ($urandom % 16) == 0;
      sel_blk = BW'($urandom);
      sel_wdata = 6'($urandom);
      glb_we = ($urandom % 32) == 0;
      glb_en = NBLK'($urandom | $urandom);
      glb_cut = 5'($urandom % 6);
      key_valid = ($urandom % 4) != 0;
      key_egress = $urandom % 2;
      for (int k = 0; k < 8; k++) begin
        key_sip[16*k +: 16] = small16();
        key_dip[16*k +: 16] = small16();
      end
      for (int k = 0; k < 3; k++) begin
        key_smac[16*k +: 16] = small16();
        key_dmac[16*k +: 16] = small16();
      end
      for (int k = 0; k < 4; k++) key_spm[16*k +: 16] = small16();
      key_etype = small16(); key_itag = small16(); key_tosp = small16();
      key_sport = small16(); key_dport = small16(); key_icmp = small16();
      key_fix = 20'($urandom & $urandom);
      tick("R2 random templates and priority R8");
    end
    rule_we = 0; sel_we = 0; glb_we = 0; key_valid = 0;
    tick("R9 idle after traffic");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule